// File: doc/BRIEF.md
# MDIO Management Master

This block is a management-bus master that sends IEEE 802.3 MDIO frames to external PHY devices, in either the short (Clause 22) or the extended (Clause 45) frame format. Software programs it through four 32-bit word registers on a simple write/read port. One register holds the configuration, the format and the status. The others are a target register (port address, device or register number, read launch), an extended-address register and a data register.

A frame starts in one of three ways. Writing the target register with its read bit set starts a read. Writing the data register starts a write. In extended mode, writing the address register starts an address frame. The block derives MDC from the system clock with a programmable divider, shifts the frame out on MDIO and releases the line for the turnaround and data of a read. It captures the returned bits, flags a missing PHY and reports busy state per frame type.

The register port has no stream traffic and no back-pressure. Every write is accepted in one cycle, and any write that arrives while a frame is pending or running is discarded. Reads are combinational.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset, register 0 (CFG) reads 0x0102_0000: divider 258 in bits [24:16], and busy, read-error, extended-format (bit 2) and fall-sample (bit 3) all 0. The CTRL (1), ADDR (2) and DATA (3) registers read 0, MDC is low and the MDIO output enable is low. A CFG write updates bits 2, 3 and [24:16], which read back as written.
- R2: While a frame runs, MDC has a period of 2 × (divider + 1) system clocks. A divider of 258 works.
- R3: With CFG bit 2 clear, a DATA write (value in bits [15:0]) sends 32 ones, start 01, opcode 01, the 5-bit port (CTRL bits [12:8]) and the 5-bit register number (CTRL bits [4:0]), both MSB first, then turnaround 10 and the 16 data bits MSB first.
- R4: With CFG bit 2 set, an ADDR write sends an address frame: start 00, opcode 00, port, device, turnaround 10, then the 16-bit address. With bit 2 clear, an ADDR write only stores the value and sends nothing.
- R5: With CFG bit 2 set, a DATA write sends start 00, opcode 01, port, device, turnaround 10 and the data.
- R6: A CTRL write with bit 15 set sends a read frame: start 01 with opcode 10 in short format, or start 00 with opcode 11 in extended format. The output enable drops for the last 18 bit times, and the 16 returned bits land in DATA[15:0].
- R7: CFG bit 0 is set only while an address frame is pending or running. DATA bit 31 is set only while a read or write frame is pending or running.
- R8: If MDIO is high at the second turnaround bit of a read, CFG bit 1 is set and DATA[15:0] becomes 0xFFFF. A read that completes with a good turnaround clears the flag.
- R9: While a frame is pending or running, writes to any register are ignored and no second frame is queued.
- R10: Driven MDIO bits change only at MDC falling edges. Read data is captured correctly whether it is sampled at the rising edge (bit 3 clear) or at the next falling edge (bit 3 set).
- R11: A frame lasts exactly 64 MDC periods. Afterwards MDC stays low and the output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_waddr | input | 2 | Word index of the register being written |
| bus_wdata | input | 32 | Write data |
| bus_raddr | input | 2 | Word index of the register being read |
| bus_rdata | output | 32 | Read data, combinational |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | MDIO output enable, high while the master drives |
| mdio_i | input | 1 | MDIO value seen on the pad |

## Verification
A register write is taken at a clock edge. The launch flag, and with it the busy bit, is set at that same edge. The sequencer goes active one edge later, and the first MDC rise comes divider + 1 clocks after that. Each bit then takes 2 × (divider + 1) clocks, and read data reaches DATA one clock after the final MDC fall. Rather than counting a fixed number of cycles, the checks poll the busy bits and read the registers half a clock after an edge. Line bits are captured at each MDC rise, and MDC periods are measured by time between rises.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  typedef enum logic [1:0] {
    FK_ADDR  = 2'd0,
    FK_WRITE = 2'd1,
    FK_READ  = 2'd2
  } frame_kind_e;

  localparam logic [1:0] RA_CFG  = 2'd0;
  localparam logic [1:0] RA_CTRL = 2'd1;
  localparam logic [1:0] RA_ADDR = 2'd2;
  localparam logic [1:0] RA_DATA = 2'd3;

  localparam int CFG_BUSY  = 0;
  localparam int CFG_RDERR = 1;
  localparam int CFG_C45   = 2;
  localparam int CFG_SMPF  = 3;
  localparam int CFG_DIV   = 16;
  localparam int CTRL_DEV  = 0;
  localparam int CTRL_PORT = 8;
  localparam int CTRL_RD   = 15;
  localparam int DATA_BUSY = 31;
  localparam int FLD_W     = 5;
  localparam int WORD_W    = 16;
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int DIV_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             rise_tick,
  output logic             fall_tick
);
  logic [DIV_W-1:0] cnt;
  logic             wrap;

  assign wrap      = run && (cnt == div);
  assign rise_tick = wrap && !mdc;
  assign fall_tick = wrap && mdc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R2: the half-period counter never passes the programmed divider
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt <= div));
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_pkg::*;
#(
  parameter int PRE_BITS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  frame_kind_e       kind,
  input  logic              c45,
  input  logic [FLD_W-1:0]  port,
  input  logic [FLD_W-1:0]  dev,
  input  logic [WORD_W-1:0] payload,
  input  logic              smp_fall,
  input  logic              rise_tick,
  input  logic              fall_tick,
  input  logic              mdio_i,
  output logic              active,
  output logic              done,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic [WORD_W-1:0] rd_data,
  output logic              ta_err
);
  localparam int FRAME_BITS = PRE_BITS + 4 + 2 * FLD_W + 2 + WORD_W;
  localparam int IDX_W      = $clog2(FRAME_BITS + 1);
  localparam int REL_IDX    = PRE_BITS + 4 + 2 * FLD_W;
  localparam int TA2_IDX    = REL_IDX + 1;
  localparam int DAT_IDX    = REL_IDX + 2;

  logic [FRAME_BITS-1:0] sh;
  logic [FRAME_BITS-1:0] frame_w;
  logic [IDX_W-1:0]      idx;
  logic                  is_rd;
  logic [1:0]            st, op, ta;
  logic [WORD_W-1:0]     body;
  logic                  smp;

  always_comb begin
    if (c45) begin
      st = 2'b00;
      unique case (kind)
        FK_ADDR:  op = 2'b00;
        FK_WRITE: op = 2'b01;
        default:  op = 2'b11;
      endcase
    end else begin
      st = 2'b01;
      op = (kind == FK_READ) ? 2'b10 : 2'b01;
    end
    ta   = (kind == FK_READ) ? 2'b11 : 2'b10;
    body = (kind == FK_READ) ? '1 : payload;
  end

  assign frame_w = {{PRE_BITS{1'b1}}, st, op, port, dev, ta, body};
  assign smp     = smp_fall ? fall_tick : rise_tick;
  assign mdio_o  = sh[FRAME_BITS-1];
  assign mdio_oe = active && !(is_rd && (idx >= IDX_W'(REL_IDX)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh      <= '1;
      idx     <= '0;
      active  <= 1'b0;
      done    <= 1'b0;
      is_rd   <= 1'b0;
      rd_data <= '0;
      ta_err  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        sh      <= frame_w;
        idx     <= '0;
        active  <= 1'b1;
        is_rd   <= (kind == FK_READ);
        rd_data <= '0;
        ta_err  <= 1'b0;
      end else if (active) begin
        if (smp && is_rd) begin
          if (idx == IDX_W'(TA2_IDX)) ta_err <= mdio_i;
          if (idx >= IDX_W'(DAT_IDX)) rd_data <= {rd_data[WORD_W-2:0], mdio_i};
        end
        if (fall_tick) begin
          sh <= {sh[FRAME_BITS-2:0], 1'b1};
          if (idx == IDX_W'(FRAME_BITS - 1)) begin
            active <= 1'b0;
            done   <= 1'b1;
          end else begin
            idx <= idx + 1'b1;
          end
        end
      end
    end
  end

  // R10: the driven bit only moves on an MDC falling edge
  p_drive_on_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active) && !$past(fall_tick)) |-> $stable(mdio_o));

  // R11: a frame ends only on an MDC falling edge
  p_end_on_fall_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(fall_tick));
endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
  import mdio_pkg::*;
#(
  parameter int             DIV_W   = 9,
  parameter logic [DIV_W-1:0] DIV_RST = 9'd258
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [1:0]        bus_waddr,
  input  logic [31:0]       bus_wdata,
  input  logic [1:0]        bus_raddr,
  output logic [31:0]       bus_rdata,
  input  logic              active,
  input  logic              done,
  input  logic [WORD_W-1:0] rd_data,
  input  logic              ta_err,
  output logic              start,
  output frame_kind_e       kind,
  output logic              c45,
  output logic              smp_fall,
  output logic [DIV_W-1:0]  div,
  output logic [FLD_W-1:0]  port,
  output logic [FLD_W-1:0]  dev,
  output logic [WORD_W-1:0] payload
);
  logic              start_q;
  logic              busy;
  logic              rd_err_q;
  logic [WORD_W-1:0] addr_q;
  logic [WORD_W-1:0] data_q;
  logic              wr_ok;

  assign busy    = active || start_q;
  assign wr_ok   = bus_wr && !busy;
  assign start   = start_q;
  assign payload = (kind == FK_ADDR) ? addr_q : data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q  <= 1'b0;
      kind     <= FK_WRITE;
      c45      <= 1'b0;
      smp_fall <= 1'b0;
      div      <= DIV_RST;
      port     <= '0;
      dev      <= '0;
      addr_q   <= '0;
      data_q   <= '0;
      rd_err_q <= 1'b0;
    end else begin
      start_q <= 1'b0;
      if (start_q) rd_err_q <= 1'b0;
      if (done && kind == FK_READ) begin
        rd_err_q <= ta_err;
        data_q   <= ta_err ? '1 : rd_data;
      end
      if (wr_ok) begin
        unique case (bus_waddr)
          RA_CFG: begin
            c45      <= bus_wdata[CFG_C45];
            smp_fall <= bus_wdata[CFG_SMPF];
            div      <= bus_wdata[CFG_DIV +: DIV_W];
          end
          RA_CTRL: begin
            dev  <= bus_wdata[CTRL_DEV +: FLD_W];
            port <= bus_wdata[CTRL_PORT +: FLD_W];
            if (bus_wdata[CTRL_RD]) begin
              start_q <= 1'b1;
              kind    <= FK_READ;
            end
          end
          RA_ADDR: begin
            addr_q <= bus_wdata[WORD_W-1:0];
            if (c45) begin
              start_q <= 1'b1;
              kind    <= FK_ADDR;
            end
          end
          default: begin
            data_q  <= bus_wdata[WORD_W-1:0];
            start_q <= 1'b1;
            kind    <= FK_WRITE;
          end
        endcase
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (bus_raddr)
      RA_CFG: begin
        bus_rdata[CFG_BUSY]          = busy && (kind == FK_ADDR);
        bus_rdata[CFG_RDERR]         = rd_err_q;
        bus_rdata[CFG_C45]           = c45;
        bus_rdata[CFG_SMPF]          = smp_fall;
        bus_rdata[CFG_DIV +: DIV_W]  = div;
      end
      RA_CTRL: begin
        bus_rdata[CTRL_DEV +: FLD_W]  = dev;
        bus_rdata[CTRL_PORT +: FLD_W] = port;
      end
      RA_ADDR: bus_rdata[WORD_W-1:0] = addr_q;
      default: begin
        bus_rdata[WORD_W-1:0] = data_q;
        bus_rdata[DATA_BUSY]  = busy && (kind != FK_ADDR);
      end
    endcase
  end

  // R9: configuration cannot move while a frame is pending or running
  p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(div) && $stable(c45) && $stable(smp_fall)));

  // R9: a launch is only raised while the sequencer is idle
  p_launch_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> !active);

  // R8: a flagged read leaves all ones in the data register
  p_err_ones_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_err_q && !busy) |-> (data_q == '1));
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_pkg::*;
#(
  parameter int               PRE_BITS = 32,
  parameter int               DIV_W    = 9,
  parameter logic [DIV_W-1:0] DIV_RST  = 9'd258
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [1:0]  bus_waddr,
  input  logic [31:0] bus_wdata,
  input  logic [1:0]  bus_raddr,
  output logic [31:0] bus_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic              start, c45, smp_fall, active, done, ta_err;
  logic              rise_tick, fall_tick;
  frame_kind_e       kind;
  logic [DIV_W-1:0]  div;
  logic [FLD_W-1:0]  port, dev;
  logic [WORD_W-1:0] payload, rd_data;

  mdio_regs #(.DIV_W(DIV_W), .DIV_RST(DIV_RST)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_wr(bus_wr), .bus_waddr(bus_waddr), .bus_wdata(bus_wdata),
    .bus_raddr(bus_raddr), .bus_rdata(bus_rdata),
    .active(active), .done(done), .rd_data(rd_data), .ta_err(ta_err),
    .start(start), .kind(kind), .c45(c45), .smp_fall(smp_fall),
    .div(div), .port(port), .dev(dev), .payload(payload)
  );

  mdio_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst_n(rst_n), .run(active), .div(div),
    .mdc(mdc), .rise_tick(rise_tick), .fall_tick(fall_tick)
  );

  mdio_frame_seq #(.PRE_BITS(PRE_BITS)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .kind(kind), .c45(c45),
    .port(port), .dev(dev), .payload(payload), .smp_fall(smp_fall),
    .rise_tick(rise_tick), .fall_tick(fall_tick), .mdio_i(mdio_i),
    .active(active), .done(done), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .rd_data(rd_data), .ta_err(ta_err)
  );

  // R11: between frames the bus is quiet and undriven
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (!mdc && !mdio_oe));
endmodule

// File: tb/tb_mdio_mgmt_master.sv
`timescale 1ns/1ps
module tb_mdio_mgmt_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_waddr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [1:0]  bus_raddr = 2'd0;
  logic [31:0] bus_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_line;
  logic        phy_drv = 1'b0, phy_o = 1'b1;
  logic        phy_on = 1'b1, rd_frame = 1'b0;
  logic [15:0] phy_val = '0;
  logic [63:0] cap = '0;
  int          nrise = 0;
  int          bad_chg = 0;
  logic        prev_o = 1'b1;
  int          checks = 0, failures = 0;

  always #5 clk = ~clk;

  assign mdio_line = mdio_oe ? mdio_o : (phy_drv ? phy_o : 1'b1);

  mdio_mgmt_master dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_waddr(bus_waddr),
    .bus_wdata(bus_wdata), .bus_raddr(bus_raddr), .bus_rdata(bus_rdata),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_line)
  );

  always @(posedge mdc) begin
    cap = {cap[62:0], mdio_line};
    nrise++;
  end

  always @(negedge mdc) begin
    if (rd_frame && phy_on && nrise >= 47 && nrise <= 63) begin
      phy_drv = 1'b1;
      phy_o   = (nrise == 47) ? 1'b0 : phy_val[63 - nrise];
    end else begin
      phy_drv = 1'b0;
    end
  end

  always @(negedge clk) begin
    if (mdio_oe && mdc && mdio_o !== prev_o) bad_chg++;
    prev_o = mdio_o;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_waddr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_raddr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] c, d;
    for (int i = 0; i < 40000; i++) begin
      rd(2'd0, c);
      rd(2'd3, d);
      if (!c[0] && !d[31]) break;
    end
  endtask

  task automatic arm(input bit is_rd);
    cap = '0; nrise = 0; rd_frame = is_rd;
  endtask

  function automatic logic [63:0] mk(input logic [1:0] st, input logic [1:0] op,
      input logic [4:0] p, input logic [4:0] dv, input logic [1:0] ta, input logic [15:0] dat);
    return {32'hFFFF_FFFF, st, op, p, dv, ta, dat};
  endfunction

  task automatic t_reset();
    logic [31:0] v;
    rd(2'd0, v); chk(v == 32'h0102_0000, "R1 cfg reset", v, 32'h0102_0000);
    rd(2'd1, v); chk(v == 0, "R1 ctrl reset", v, 0);
    rd(2'd3, v); chk(v == 0, "R1 data reset", v, 0);
    chk(!mdc && !mdio_oe, "R1 idle pins", {mdc, mdio_oe}, 0);
    wr(2'd0, 32'h0001_000C);
    rd(2'd0, v); chk(v == 32'h0001_000C, "R1 cfg readback", v, 32'h0001_000C);
    wr(2'd0, 32'h0001_0000);
  endtask

  task automatic t_c22_write();
    logic [31:0] c, d;
    arm(0);
    wr(2'd1, 32'h0000_050A);
    wr(2'd3, 32'h0000_BEEF);
    repeat (20) @(negedge clk);
    rd(2'd0, c); rd(2'd3, d);
    chk(!c[0] && d[31], "R7 busy during write", {c[0], d[31]}, 2'b01);
    wait_idle();
    chk(cap == mk(2'b01, 2'b01, 5'd5, 5'h0A, 2'b10, 16'hBEEF), "R3 c22 write frame", cap,
        mk(2'b01, 2'b01, 5'd5, 5'h0A, 2'b10, 16'hBEEF));
    chk(nrise == 64, "R11 frame length", nrise, 64);
    chk(!mdc && !mdio_oe, "R11 idle after frame", {mdc, mdio_oe}, 0);
  endtask

  task automatic t_c22_addr_noop();
    logic [31:0] v;
    arm(0);
    wr(2'd2, 32'h0000_1234);
    repeat (40) @(negedge clk);
    chk(nrise == 0, "R4 no frame in short mode", nrise, 0);
    rd(2'd2, v); chk(v == 32'h1234, "R4 addr stored", v, 32'h1234);
  endtask

  task automatic t_c45_addr_write();
    logic [31:0] c, d;
    wr(2'd0, 32'h0001_0004);
    wr(2'd1, 32'h0000_0301);
    arm(0);
    wr(2'd2, 32'h0000_0042);
    repeat (20) @(negedge clk);
    rd(2'd0, c); rd(2'd3, d);
    chk(c[0] && !d[31], "R7 busy during address", {c[0], d[31]}, 2'b10);
    wait_idle();
    chk(cap == mk(2'b00, 2'b00, 5'd3, 5'd1, 2'b10, 16'h0042), "R4 c45 address frame", cap,
        mk(2'b00, 2'b00, 5'd3, 5'd1, 2'b10, 16'h0042));
    arm(0);
    wr(2'd3, 32'h0000_5A5A);
    wait_idle();
    chk(cap == mk(2'b00, 2'b01, 5'd3, 5'd1, 2'b10, 16'h5A5A), "R5 c45 write frame", cap,
        mk(2'b00, 2'b01, 5'd3, 5'd1, 2'b10, 16'h5A5A));
  endtask

  task automatic t_c45_read();
    logic [31:0] c, d;
    phy_on = 1'b1; phy_val = 16'hC3A5;
    arm(1);
    wr(2'd1, 32'h0000_8301);
    wait_idle();
    rd(2'd3, d); rd(2'd0, c);
    chk(cap == mk(2'b00, 2'b11, 5'd3, 5'd1, 2'b10, 16'hC3A5), "R6 c45 read frame", cap,
        mk(2'b00, 2'b11, 5'd3, 5'd1, 2'b10, 16'hC3A5));
    chk(d[15:0] == 16'hC3A5, "R6 c45 read data", d[15:0], 16'hC3A5);
    chk(!c[1], "R8 no error on good read", c[1], 0);
  endtask

  task automatic t_c22_read_fall();
    logic [31:0] d;
    wr(2'd0, 32'h0001_0008);
    phy_on = 1'b1; phy_val = 16'h0F1E;
    arm(1);
    wr(2'd1, 32'h0000_8702);
    wait_idle();
    rd(2'd3, d);
    chk(cap == mk(2'b01, 2'b10, 5'd7, 5'd2, 2'b10, 16'h0F1E), "R6 c22 read frame", cap,
        mk(2'b01, 2'b10, 5'd7, 5'd2, 2'b10, 16'h0F1E));
    chk(d[15:0] == 16'h0F1E, "R10 fall-sampled read data", d[15:0], 16'h0F1E);
    wr(2'd0, 32'h0001_0000);
  endtask

  task automatic t_read_err();
    logic [31:0] c, d;
    phy_on = 1'b0;
    arm(1);
    wr(2'd1, 32'h0000_8404);
    wait_idle();
    rd(2'd0, c); rd(2'd3, d);
    chk(c[1], "R8 error flag set", c[1], 1);
    chk(d[15:0] == 16'hFFFF, "R8 all ones on error", d[15:0], 16'hFFFF);
    phy_on = 1'b1; phy_val = 16'h1357;
    arm(1);
    wr(2'd1, 32'h0000_8404);
    wait_idle();
    rd(2'd0, c); rd(2'd3, d);
    chk(!c[1] && d[15:0] == 16'h1357, "R8 flag cleared by good read", {c[1], d[15:0]}, {1'b0, 16'h1357});
  endtask

  task automatic t_busy_ignore();
    logic [31:0] c, d;
    phy_on = 1'b1; phy_val = 16'hA55A;
    arm(1);
    wr(2'd1, 32'h0000_8203);
    repeat (10) @(negedge clk);
    wr(2'd3, 32'h0000_1111);
    wr(2'd1, 32'h0000_8C0C);
    wr(2'd0, 32'h0005_0004);
    wait_idle();
    repeat (300) @(negedge clk);
    rd(2'd3, d); rd(2'd0, c); 
    chk(d[15:0] == 16'hA55A, "R9 data write ignored", d[15:0], 16'hA55A);
    chk(c == 32'h0001_0000, "R9 cfg write ignored", c, 32'h0001_0000);
    chk(nrise == 64, "R9 no queued frame", nrise, 64);
    rd(2'd1, c); chk(c == 32'h0000_0203, "R9 ctrl write ignored", c, 32'h0203);
  endtask

  task automatic t_period(input int dv);
    realtime t0, t1;
    wr(2'd0, dv << 16);
    arm(0);
    wr(2'd3, 32'h0000_0F0F);
    @(posedge mdc); t0 = $realtime;
    @(posedge mdc); t1 = $realtime;
    chk((t1 - t0) == 20.0 * (dv + 1), "R2 mdc period", longint'(t1 - t0), 20 * (dv + 1));
    wait_idle();
    chk(nrise == 64, "R2 frame completes at divider", nrise, 64);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_c22_write();
    t_c22_addr_noop();
    t_c45_addr_write();
    t_c45_read();
    wr(2'd0, 32'h0001_0000);
    t_c22_read_fall();
    t_read_err();
    t_busy_ignore();
    t_period(3);
    t_period(258);
    chk(bad_chg == 0, "R10 driven bits change on falling edge", bad_chg, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule